// File: doc/BRIEF.md
# Priority Interrupt Vector Receiver

This block collects interrupt vectors posted to one hardware thread and hands them to the core one at a time. Each post carries a vector number, and the block records it as one bit in a pending bitmap. The block keeps as many vectors pending at once as it has bits. While any are pending and the core's interrupt enable is high, a registered trap request is raised toward the core.

The core's trap handler reads the incoming-vector port to find out which vector to service. That port always shows the highest-numbered pending vector. When the handler asserts the read strobe, the bit for that vector is cleared at the next clock edge, so each posted vector becomes exactly one trap. A second output exposes the whole pending bitmap without disturbing it. Software can use it to confirm that a vector is pending before it is taken and gone after it is taken.

Top module: `irq_vector_rx`

## Requirements
- R1: A cycle with `post_valid` high and `post_vec` = N sets bit N of `pend_map`, visible after the next rising edge.
- R2: Posts of different vectors accumulate; earlier pending bits are kept when later ones are set.
- R3: While `intr_en` is low, `trap_req` stays low and pending bits are kept unchanged.
- R4: `trap_req` is a register that, at each rising edge, captures (`pend_map` is nonzero) AND `intr_en`, using the values present before that edge.
- R5: `vec_id` shows the index of the highest-numbered set bit of `pend_map`, and 0 when no bit is set.
- R6: A cycle with `vec_rd` high clears the bit whose index `vec_id` shows in that cycle; the clear is visible after the next rising edge.
- R7: `pend_map` may be observed any number of cycles without changing it; a pending bit is visible there before its vector is read.
- R8: If a post sets the same bit that a read clears in the same cycle, the bit ends up set.
- R9: A read while nothing is pending returns 0 on `vec_id` and leaves `pend_map` at zero.
- R10: Asserting `rst_n` low clears every pending bit and `trap_req`.
- R11: After the read that clears the last pending bit, `trap_req` falls one cycle later than `pend_map` becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| post_valid | input | 1 | Strobe: post the vector on `post_vec` |
| post_vec | input | VW (6) | Vector number to post |
| intr_en | input | 1 | Core interrupt enable |
| vec_rd | input | 1 | Strobe: take the vector shown on `vec_id` and clear it |
| vec_id | output | VW (6) | Highest-numbered pending vector, 0 if none |
| pend_map | output | NUM_VEC (64) | Pending bitmap, read without side effect |
| trap_req | output | 1 | Registered trap request to the core |

## Verification
The bench builds the block with its default 64 vectors and a 6-bit vector number. This puts both ends of the range within reach: vector 63 must win over everything else, and vector 0 is a real pending vector that reads back as 0, just like an empty read. The bench replays a masked burst of posts 5, 1, 7 and checks that they drain as 7, 5, 1. It also checks a set-versus-clear collision on one bit and the one-cycle lag of the trap request behind the bitmap.

// File: rtl/irq_rx_pkg.sv
package irq_rx_pkg;
  localparam int unsigned IRQ_NUM_VEC_DEF = 64;
  localparam int unsigned IRQ_VW_DEF      = $clog2(IRQ_NUM_VEC_DEF);
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_VEC = 64,
  parameter int unsigned VW      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VW-1:0]      set_idx,
  input  logic               clr_en,
  input  logic [VW-1:0]      clr_idx,
  output logic [NUM_VEC-1:0] pend_q
);
  logic [NUM_VEC-1:0] pend_d;
  logic [NUM_VEC-1:0] bit_ce;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
    logic set_hit, clr_hit;
    always_comb begin
      set_hit   = set_en && (set_idx == VW'(i));
      clr_hit   = clr_en && (clr_idx == VW'(i));
      bit_ce[i] = set_hit | clr_hit;
      // a new post wins over a clear of the same bit
      pend_d[i] = set_hit ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q[i] <= 1'b0;
      else if (bit_ce[i]) pend_q[i] <= pend_d[i];
    end
  end

  // R1: a posted index is pending after the edge
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_idx)]);

  // R8: set wins a same-bit collision
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_en && set_idx == clr_idx) |=> pend_q[$past(set_idx)]);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_VEC = 64,
  parameter int unsigned VW      = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req,
  output logic [VW-1:0]      top_idx,
  output logic               any
);
  always_comb begin
    top_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (req[i]) begin
        top_idx = VW'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vector_rx.sv
module irq_vector_rx
  import irq_rx_pkg::*;
#(
  parameter int unsigned NUM_VEC = IRQ_NUM_VEC_DEF,
  parameter int unsigned VW      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_valid,
  input  logic [VW-1:0]      post_vec,
  input  logic               intr_en,
  input  logic               vec_rd,
  output logic [VW-1:0]      vec_id,
  output logic [NUM_VEC-1:0] pend_map,
  output logic               trap_req
);
  logic pend_any;
  logic take;
  logic trap_d, trap_q;

  irq_prio_enc #(.NUM_VEC(NUM_VEC), .VW(VW)) u_enc (
    .req     (pend_map),
    .top_idx (vec_id),
    .any     (pend_any)
  );

  always_comb take = vec_rd && pend_any;

  irq_pend_bank #(.NUM_VEC(NUM_VEC), .VW(VW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (post_valid),
    .set_idx (post_vec),
    .clr_en  (take),
    .clr_idx (vec_id),
    .pend_q  (pend_map)
  );

  always_comb trap_d = pend_any && intr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign trap_req = trap_q;

  // R3: masked interrupts never trap
  a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_en |=> !trap_req);

  // R5: vec_id points at the top set bit
  a_r5_highest: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_map != '0) |-> ((pend_map >> vec_id) == NUM_VEC'(1)));

  // R6: a taken vector is gone unless reposted
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && pend_map != '0 && !(post_valid && post_vec == vec_id))
      |=> !pend_map[$past(vec_id)]);

  // R9: an empty read changes nothing
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && pend_map == '0 && !post_valid) |=> (pend_map == '0));
endmodule

// File: tb/irq_vector_rx_bench.sv
module irq_vector_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 64;
  localparam int VW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic post_valid, intr_en, vec_rd;
  logic [VW-1:0] post_vec, vec_id;
  logic [NV-1:0] pend_map;
  logic trap_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_rx #(.NUM_VEC(NV), .VW(VW)) u_irq_vector_rx (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_vec(post_vec),
    .intr_en(intr_en), .vec_rd(vec_rd), .vec_id(vec_id),
    .pend_map(pend_map), .trap_req(trap_req)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic post(int v);
    post_valid = 1'b1; post_vec = VW'(v);
    step();
    post_valid = 1'b0;
  endtask

  task automatic take(string req, int exp);
    chk(req, 64'(vec_id), 64'(exp));
    vec_rd = 1'b1;
    step();
    vec_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; post_valid = 1'b0; post_vec = '0; intr_en = 1'b0; vec_rd = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R10 pend after reset", pend_map, 64'h0);
    chk("R10 trap after reset", 64'(trap_req), 64'h0);
    chk("R5 empty vec_id", 64'(vec_id), 64'h0);
  endtask

  task automatic t_masked_burst();
    intr_en = 1'b0;
    post(5);
    chk("R1 vector 5 bit", pend_map, 64'h20);
    post(1); post(7);
    step(); step();
    chk("R2 burst accumulates", pend_map, 64'hA2);
    chk("R3 no trap while masked", 64'(trap_req), 64'h0);
  endtask

  task automatic t_priority_drain();
    intr_en = 1'b1;
    chk("R4 trap not yet registered", 64'(trap_req), 64'h0);
    step();
    chk("R4 trap raised", 64'(trap_req), 64'h1);
    chk("R7 bit 7 visible before read", 64'(pend_map[7]), 64'h1);
    take("R5 first vector 7", 7);
    chk("R6 bit 7 cleared", pend_map, 64'h22);
    take("R5 second vector 5", 5);
    chk("R6 bit 5 cleared", pend_map, 64'h02);
    take("R5 third vector 1", 1);
    chk("R6 all cleared", pend_map, 64'h0);
    chk("R11 trap lags one cycle", 64'(trap_req), 64'h1);
    step();
    chk("R11 trap dropped", 64'(trap_req), 64'h0);
  endtask

  task automatic t_empty_read();
    take("R9 empty read value", 0);
    chk("R9 map unchanged", pend_map, 64'h0);
    step();
    chk("R9 no trap", 64'(trap_req), 64'h0);
  endtask

  task automatic t_collision();
    post(9);
    chk("R1 vector 9", pend_map, 64'h200);
    post_valid = 1'b1; post_vec = 6'd9;
    take("R8 read sees 9", 9);
    post_valid = 1'b0;
    chk("R8 set wins", pend_map, 64'h200);
    take("R6 drain 9", 9);
    chk("R6 9 cleared", pend_map, 64'h0);
    step();
  endtask

  task automatic t_range_ends();
    post(0); post(63);
    chk("R2 ends pending", pend_map, 64'h8000_0000_0000_0001);
    take("R5 vector 63 first", 63);
    chk("R5 vector 0 shows 0", 64'(vec_id), 64'h0);
    take("R6 vector 0 taken", 0);
    chk("R6 ends cleared", pend_map, 64'h0);
    step();
  endtask

  task automatic t_peek_and_mask();
    post(12);
    for (int k = 0; k < 3; k++) step();
    chk("R7 peek keeps bit", pend_map, 64'h1000);
    chk("R4 trap up", 64'(trap_req), 64'h1);
    intr_en = 1'b0;
    chk("R4 trap lags mask", 64'(trap_req), 64'h1);
    step();
    chk("R3 masked trap low", 64'(trap_req), 64'h0);
    chk("R3 pending kept", pend_map, 64'h1000);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R10 reset clears pending", pend_map, 64'h0);
    step();
  endtask

  initial begin
    t_reset();
    t_masked_burst();
    t_priority_drain();
    t_empty_read();
    t_collision();
    t_range_ends();
    t_peek_and_mask();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule